// File: doc/BRIEF.md
# Software-Generated Interrupt Acceptance Filter

This block decides whether a request to raise one of the sixteen local software-generated interrupts (SGIs) of a processor target is allowed to mark that SGI pending. Each request carries the group the sender asked for, the SGI number and a flag that says whether it came from the non-secure world. The filter compares the request with the group the target has configured for that SGI, and, when security is enabled and the sender is non-secure, also with a two-bit access level that the block keeps for each SGI in a 32-bit access control register.

An accepted request sets the SGI's bit in a sticky 16-bit pending vector and raises a one-cycle accept pulse. A refused request leaves no trace. Register-bus decode and the routing of requests to targets sit outside the block. The configured group is given as two 16-bit vectors: a group bit and a group-modifier bit per SGI.

Top module: `sgi_accept_filter`

## Requirements
- R1: While reset is asserted and after its release, before any request, the pending vector, the accept pulse and the access control register all read zero.
- R2: The configured group of SGI n is non-secure Group 1 when group bit n is 1, secure Group 1 when group bit n is 0 and modifier bit n is 1, and Group 0 when both are 0.
- R3: Request group codes are 2'b00 Group 0, 2'b01 secure Group 1, 2'b10 non-secure Group 1; a secure Group 1 request aimed at an SGI configured as Group 0 is handled as a Group 0 request.
- R4: After the R3 adjustment a request whose group differs from the configured group is dropped; the unused code 2'b11 never matches and is always dropped.
- R5: The access level of SGI n is bits [2n+1:2n] of the access control register; a write through the write port shows on the register output one cycle later, and a request in the write cycle is judged with the old value.
- R6: A non-secure request with security enabled needs an access level of at least 1 for a Group 0 SGI and at least 2 for a secure Group 1 SGI; a non-secure Group 1 SGI is not gated by the level.
- R7: With the security-disable input high the access-level check is skipped for every group.
- R8: An accepted request raises accept for exactly the cycle after the request edge and sets the pending bit of its SGI on the same edge; the pending vector changes on no other edge.
- R9: A pending bit, once set, stays set until reset; a new accepted request for an already-pending SGI still pulses accept.
- R10: With the request-valid input low nothing is accepted, whatever the other request inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | Global security-disable control |
| grp_bits | input | 16 | Group bit per SGI |
| grpmod_bits | input | 16 | Group-modifier bit per SGI |
| acr_we | input | 1 | Access control register write enable |
| acr_wdata | input | 32 | Access control register write data |
| req_valid | input | 1 | Request present this cycle |
| req_grp | input | 2 | Requested group code |
| req_id | input | 4 | SGI number |
| req_nonsec | input | 1 | Request originates from the non-secure world |
| acr_q | output | 32 | Current access control register value |
| accept | output | 1 | One-cycle pulse for an accepted request |
| pending | output | 16 | Sticky pending vector |

## Verification
The assertions watch, on every cycle, that accept only follows a valid request and always leaves its SGI's pending bit set, that pending bits never fall and never move without accept, that the reserved group code is always refused, and that non-secure requests below the level threshold of a Group 0 or secure Group 1 SGI are refused. Only the bench's scenarios show the positive side of the decision table: that the secure Group 1 to Group 0 adjustment accepts, that security-disable and non-secure Group 1 bypass the level, that a write in the request cycle is not yet seen, and that a repeated request pulses again without changing the vector.

// File: rtl/sgi_filt_pkg.sv
package sgi_filt_pkg;
  typedef enum logic [1:0] {
    GRP_G0   = 2'b00,
    GRP_G1S  = 2'b01,
    GRP_G1NS = 2'b10,
    GRP_RSVD = 2'b11
  } sgi_grp_e;
endpackage

// File: rtl/sgi_group_resolve.sv
module sgi_group_resolve
  import sgi_filt_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int ID_W = $clog2(NUM_SGI)
) (
  input  logic [NUM_SGI-1:0] grp_bits,
  input  logic [NUM_SGI-1:0] grpmod_bits,
  input  logic [ID_W-1:0]    req_id,
  input  logic [1:0]         req_grp,
  output sgi_grp_e           cfg_grp,
  output logic               grp_ok
);
  logic     sel_grp;
  logic     sel_mod;
  sgi_grp_e eff_grp;

  // pick the configuration bits of the addressed SGI
  always_comb begin
    sel_grp = 1'b0;
    sel_mod = 1'b0;
    for (int i = 0; i < NUM_SGI; i++) begin
      if (req_id == i[ID_W-1:0]) begin
        sel_grp = grp_bits[i];
        sel_mod = grpmod_bits[i];
      end
    end
  end

  // configured group from group and modifier bits
  always_comb begin
    if (sel_grp)      cfg_grp = GRP_G1NS;
    else if (sel_mod) cfg_grp = GRP_G1S;
    else              cfg_grp = GRP_G0;
  end

  // a secure group 1 request may land on a group 0 SGI
  always_comb begin
    eff_grp = sgi_grp_e'(req_grp);
    if ((eff_grp == GRP_G1S) && (cfg_grp == GRP_G0)) eff_grp = GRP_G0;
    grp_ok = (eff_grp == cfg_grp);
  end
endmodule

// File: rtl/sgi_ns_gate.sv
module sgi_ns_gate
  import sgi_filt_pkg::*;
#(
  parameter int NUM_SGI    = 16,
  parameter int LVL_W      = 2,
  parameter int G0_MIN_LVL = 1,
  parameter int G1S_MIN_LVL = 2,
  localparam int ID_W  = $clog2(NUM_SGI),
  localparam int ACR_W = NUM_SGI * LVL_W
) (
  input  logic [ACR_W-1:0] acr,
  input  logic [ID_W-1:0]  req_id,
  input  sgi_grp_e         cfg_grp,
  input  logic             req_nonsec,
  input  logic             sec_disable,
  output logic             lvl_ok
);
  localparam logic [LVL_W-1:0] G0_THR  = LVL_W'(G0_MIN_LVL);
  localparam logic [LVL_W-1:0] G1S_THR = LVL_W'(G1S_MIN_LVL);

  logic [LVL_W-1:0] lvl;

  always_comb begin
    lvl = '0;
    for (int i = 0; i < NUM_SGI; i++) begin
      if (req_id == i[ID_W-1:0]) lvl = acr[i*LVL_W +: LVL_W];
    end
  end

  always_comb begin
    lvl_ok = 1'b1;
    if (req_nonsec && !sec_disable) begin
      unique case (cfg_grp)
        GRP_G0:  lvl_ok = (lvl >= G0_THR);
        GRP_G1S: lvl_ok = (lvl >= G1S_THR);
        default: lvl_ok = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/sgi_acr_reg.sv
module sgi_acr_reg #(
  parameter int NUM_SGI = 16,
  parameter int LVL_W   = 2,
  localparam int ACR_W  = NUM_SGI * LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [ACR_W-1:0] wdata,
  output logic [ACR_W-1:0] q
);
  logic [ACR_W-1:0] d;

  always_comb begin
    d = q;
    if (we) d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/sgi_pend_vec.sv
module sgi_pend_vec #(
  parameter int NUM_SGI = 16,
  localparam int ID_W   = $clog2(NUM_SGI)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [ID_W-1:0]    take_id,
  output logic               accept,
  output logic [NUM_SGI-1:0] pending
);
  logic accept_d;

  always_comb accept_d = take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accept <= 1'b0;
    else        accept <= accept_d;
  end

  for (genvar g = 0; g < NUM_SGI; g++) begin : g_bit
    logic set_en;
    logic nxt;
    always_comb begin
      set_en = take && (take_id == g[ID_W-1:0]);
      nxt    = pending[g] | set_en;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pending[g] <= 1'b0;
      else        pending[g] <= nxt;
    end
  end
endmodule

// File: rtl/sgi_accept_filter.sv
module sgi_accept_filter
  import sgi_filt_pkg::*;
#(
  parameter int NUM_SGI     = 16,
  parameter int LVL_W       = 2,
  parameter int G0_MIN_LVL  = 1,
  parameter int G1S_MIN_LVL = 2,
  localparam int ID_W  = $clog2(NUM_SGI),
  localparam int ACR_W = NUM_SGI * LVL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sec_disable,
  input  logic [NUM_SGI-1:0] grp_bits,
  input  logic [NUM_SGI-1:0] grpmod_bits,
  input  logic               acr_we,
  input  logic [ACR_W-1:0]   acr_wdata,
  input  logic               req_valid,
  input  logic [1:0]         req_grp,
  input  logic [ID_W-1:0]    req_id,
  input  logic               req_nonsec,
  output logic [ACR_W-1:0]   acr_q,
  output logic               accept,
  output logic [NUM_SGI-1:0] pending
);
  sgi_grp_e cfg_grp;
  logic     grp_ok;
  logic     lvl_ok;
  logic     take;

  sgi_acr_reg #(.NUM_SGI(NUM_SGI), .LVL_W(LVL_W)) u_acr (
    .clk(clk), .rst_n(rst_n), .we(acr_we), .wdata(acr_wdata), .q(acr_q)
  );

  sgi_group_resolve #(.NUM_SGI(NUM_SGI)) u_grp (
    .grp_bits(grp_bits), .grpmod_bits(grpmod_bits), .req_id(req_id),
    .req_grp(req_grp), .cfg_grp(cfg_grp), .grp_ok(grp_ok)
  );

  sgi_ns_gate #(
    .NUM_SGI(NUM_SGI), .LVL_W(LVL_W),
    .G0_MIN_LVL(G0_MIN_LVL), .G1S_MIN_LVL(G1S_MIN_LVL)
  ) u_gate (
    .acr(acr_q), .req_id(req_id), .cfg_grp(cfg_grp),
    .req_nonsec(req_nonsec), .sec_disable(sec_disable), .lvl_ok(lvl_ok)
  );

  always_comb take = req_valid && grp_ok && lvl_ok;

  sgi_pend_vec #(.NUM_SGI(NUM_SGI)) u_pend (
    .clk(clk), .rst_n(rst_n), .take(take), .take_id(req_id),
    .accept(accept), .pending(pending)
  );
endmodule

// File: rtl/sgi_accept_filter_chk.sv
module sgi_accept_filter_chk #(
  parameter int NUM_SGI = 16,
  parameter int LVL_W   = 2,
  localparam int ID_W  = $clog2(NUM_SGI),
  localparam int ACR_W = NUM_SGI * LVL_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sec_disable,
  input logic [NUM_SGI-1:0] grp_bits,
  input logic [NUM_SGI-1:0] grpmod_bits,
  input logic               req_valid,
  input logic [1:0]         req_grp,
  input logic [ID_W-1:0]    req_id,
  input logic               req_nonsec,
  input logic [ACR_W-1:0]   acr_q,
  input logic               accept,
  input logic [NUM_SGI-1:0] pending
);
  logic [LVL_W-1:0] lvl_now;
  logic             cfg_g0;
  logic             cfg_g1s;

  always_comb begin
    lvl_now = '0;
    cfg_g0  = 1'b0;
    cfg_g1s = 1'b0;
    for (int i = 0; i < NUM_SGI; i++) begin
      if (req_id == i[ID_W-1:0]) begin
        lvl_now = acr_q[2*i +: LVL_W];
        cfg_g0  = !grp_bits[i] && !grpmod_bits[i];
        cfg_g1s = !grp_bits[i] &&  grpmod_bits[i];
      end
    end
  end

  p_accept_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> pending[$past(req_id)]);

  p_accept_needs_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(req_valid));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pending & $past(pending)) == $past(pending)));

  p_quiet_vec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |-> $stable(pending));

  p_rsvd_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_grp == 2'b11) |=> !accept);

  p_g0_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nonsec && !sec_disable && cfg_g0 && lvl_now == '0)
      |=> !accept);

  p_g1s_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_nonsec && !sec_disable && cfg_g1s && lvl_now < 2)
      |=> !accept);
endmodule

bind sgi_accept_filter sgi_accept_filter_chk #(.NUM_SGI(NUM_SGI), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .grp_bits(grp_bits),
  .grpmod_bits(grpmod_bits), .req_valid(req_valid), .req_grp(req_grp),
  .req_id(req_id), .req_nonsec(req_nonsec), .acr_q(acr_q),
  .accept(accept), .pending(pending)
);

// File: tb/tb_sgi_accept_filter.sv
`timescale 1ns/1ps
module tb_sgi_accept_filter;
  logic        clk;
  logic        rst_n;
  logic        sec_disable;
  logic [15:0] grp_bits;
  logic [15:0] grpmod_bits;
  logic        acr_we;
  logic [31:0] acr_wdata;
  logic        req_valid;
  logic [1:0]  req_grp;
  logic [3:0]  req_id;
  logic        req_nonsec;
  logic [31:0] acr_q;
  logic        accept;
  logic [15:0] pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [15:0] exp_pend;

  sgi_accept_filter dut (
    .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .grp_bits(grp_bits),
    .grpmod_bits(grpmod_bits), .acr_we(acr_we), .acr_wdata(acr_wdata),
    .req_valid(req_valid), .req_grp(req_grp), .req_id(req_id),
    .req_nonsec(req_nonsec), .acr_q(acr_q), .accept(accept), .pending(pending)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // vector: gbit mbit lvl[1:0] | sdis ns rgrp[1:0] | id[3:0] | 000 exp
  localparam int NV = 15;
  localparam logic [15:0] VEC [NV] = '{
    16'b0000_0000_0011_0001, // R3 G0 cfg, G0 req
    16'b0000_0001_0101_0001, // R3 secure G1 req on G0 SGI
    16'b0000_0010_0110_0000, // R4 NS G1 req on G0 SGI
    16'b0100_0000_0111_0000, // R4 G0 req on secure G1 SGI
    16'b0100_0001_1000_0001, // R2 secure G1 match
    16'b1000_0110_1001_0001, // R6 NS G1 not gated at level 0
    16'b0000_0100_1010_0000, // R6 G0 ns level 0 refused
    16'b0001_0100_1010_0001, // R6 G0 ns level 1 accepted
    16'b0101_0101_1011_0000, // R6 G1S ns level 1 refused
    16'b0110_0101_1011_0001, // R6 G1S ns level 2 accepted
    16'b0100_1101_1100_0001, // R7 security disabled bypass
    16'b0011_0100_0000_0001, // R5 level 3 in field 0
    16'b1000_0011_0001_0000, // R4 reserved code dropped
    16'b0001_0101_0010_0001, // R3 adjusted then gated at G0 threshold
    16'b0000_0000_1111_0001  // R8 top SGI number
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    req_valid = 1'b0; acr_we = 1'b0;
  endtask

  task automatic run_vec(input logic [15:0] v);
    logic [3:0] id;
    id = v[7:4];
    @(negedge clk);
    grp_bits    = 16'(v[15]) << id;
    grpmod_bits = 16'(v[14]) << id;
    sec_disable = v[11];
    acr_we      = 1'b1;
    acr_wdata   = 32'(v[13:12]) << (2 * id);
    @(negedge clk);
    acr_we = 1'b0;
    req_valid = 1'b1; req_grp = v[9:8]; req_id = id; req_nonsec = v[10];
    @(negedge clk);
    req_valid = 1'b0;
    if (v[0]) exp_pend[id] = 1'b1;
    chk(accept == v[0], "R2/R3/R4/R6/R7 accept", 32'(accept), 32'(v[0]));
    chk(pending == exp_pend, "R8 pending", 32'(pending), 32'(exp_pend));
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sec_disable = 1'b0; grp_bits = '0; grpmod_bits = '0;
    acr_we = 1'b0; acr_wdata = '0; req_valid = 1'b0; req_grp = '0;
    req_id = '0; req_nonsec = 1'b0; exp_pend = '0;
    repeat (3) @(negedge clk);
    chk(pending == 16'h0 && !accept && acr_q == 32'h0, "R1 in reset",
        {pending, 15'h0, accept}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pending == 16'h0 && !accept && acr_q == 32'h0, "R1 after release",
        {pending, 15'h0, accept}, 32'h0);

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: re-request an already pending SGI (id 3, G0 secure)
    @(negedge clk);
    grp_bits = '0; grpmod_bits = '0; sec_disable = 1'b0;
    req_valid = 1'b1; req_grp = 2'b00; req_id = 4'd3; req_nonsec = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(accept == 1'b1, "R9 repeat pulses", 32'(accept), 32'h1);
    chk(pending == exp_pend, "R9 vector unchanged", 32'(pending), 32'(exp_pend));
    @(negedge clk);
    chk(accept == 1'b0, "R8 single cycle pulse", 32'(accept), 32'h0);

    // R10: passing fields but no valid
    req_grp = 2'b00; req_id = 4'd4; req_nonsec = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(accept == 1'b0 && pending[4] == 1'b0, "R10 no valid",
        {pending, 15'h0, accept}, {exp_pend, 16'h0});

    // R5: write in the request cycle is not yet seen
    acr_we = 1'b1; acr_wdata = 32'h0;
    @(negedge clk);
    acr_we = 1'b1; acr_wdata = 32'h1 << 8;
    req_valid = 1'b1; req_grp = 2'b00; req_id = 4'd4; req_nonsec = 1'b1;
    @(negedge clk);
    idle();
    chk(accept == 1'b0, "R5 old level used", 32'(accept), 32'h0);
    chk(acr_q == 32'h100, "R5 field position", acr_q, 32'h100);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    exp_pend[4] = 1'b1;
    chk(accept == 1'b1, "R5 new level used", 32'(accept), 32'h1);
    chk(pending == exp_pend, "R5 pending", 32'(pending), 32'(exp_pend));

    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    chk(pending == 16'h0 && acr_q == 32'h0, "R1 mid-run reset",
        {pending, 16'h0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule